// File: doc/BRIEF.md
# Thirty-Two Pin GPIO Port with Edge Events

This block is a general-purpose I/O port of 32 pins that sits behind a plain 32-bit register bus. Software sets, for each pin, whether it drives or listens, whether it drives push-pull or only pulls low, and the value it drives. Every pin level is brought into the clock domain through a two-stage synchronizer. A change of the synchronized level is recorded as a sticky event bit. A per-pin setting selects whether such a change counts on either transition or only on a high-to-low one.

Event bits stay set until software writes a one to them. A mask register selects which events reach the single interrupt request line. The bus is a single-cycle access: a write is taken on the clock edge where `bus_valid` and `bus_write` are both high. Read data is combinational and valid during any cycle where `bus_valid` is high and `bus_write` is low.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset every register reads zero, no pin is driven (`pad_oe` all zero) and `irq` is low.
- R2: Pin n corresponds to register bit 31−n (pin 0 is bit 31). The byte offsets are: direction 0x00, open-drain 0x04, data 0x08, event 0x0C, mask 0x10 and edge-select 0x14. A write takes effect on the clock edge that samples it.
- R3: A direction bit of 1 makes the pin an output. A direction bit of 0 keeps `pad_oe` low for that pin.
- R4: An output pin whose open-drain bit is 0 has `pad_oe` high and drives `pad_out` equal to its data bit.
- R5: An output pin whose open-drain bit is 1 drives low (`pad_oe`=1, `pad_out`=0) for data 0. For data 1 it is released (`pad_oe`=0). It never drives high.
- R6: Reading the data register returns the data bit for output pins. For input pins it returns the synchronized pad level, which follows a pad change by two clock edges.
- R7: With edge-select bit 0, both a rising and a falling synchronized change set the pin's event bit. The bit is set on the third rising clock edge after the pad change.
- R8: With edge-select bit 1, only a falling change sets the event bit; a rising change leaves it clear.
- R9: Writing 1 to an event bit clears it. Writing 0 leaves it unchanged. Event bits otherwise stay set.
- R10: If a new event on a pin arrives in the same cycle as a write that clears that pin's bit, the bit remains set.
- R11: `irq` is high exactly when some pin has both its event bit and its mask bit set (mask 1 enables).
- R12: After writing all ones to the event register and zero to the mask register, `irq` is low.
- R13: Writes to offsets outside the six listed change no register. Reads from them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read is requested |
| pad_in | input | 32 | Pad level, bit n = pin n |
| pad_out | output | 32 | Driven value, bit n = pin n |
| pad_oe | output | 32 | Output enable, bit n = pin n |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle the following properties:
- an open-drain pin never drives high, and an input pin is never enabled;
- a falling-only pin never records a rising change;
- a synchronized change always lands in the event register;
- cleared bits vanish while uncleared ones persist;
- `irq` stays low while the mask is zero.

The following can only be shown by the bench's scenarios:
- the pin-to-bit reversal and the offset map;
- the exact latency from a pad change to the readback and to the event bit;
- the case where an event and a clear of the same bit land on the same edge;
- the silence of unmapped offsets.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_DIR = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_ODE = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_DAT = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_EVT = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_MSK = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_EDG = 5'h14;

  typedef enum logic [2:0] {
    SEL_DIR,
    SEL_ODE,
    SEL_DAT,
    SEL_EVT,
    SEL_MSK,
    SEL_EDG,
    SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_DIR: return SEL_DIR;
      OFS_ODE: return SEL_ODE;
      OFS_DAT: return SEL_DAT;
      OFS_EVT: return SEL_EVT;
      OFS_MSK: return SEL_MSK;
      OFS_EDG: return SEL_EDG;
      default: return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n = stage_q[1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pad_i,
  output logic [NPIN-1:0] lvl_o,
  output logic [NPIN-1:0] prev_o
);
  logic [NPIN-1:0] meta_q, lvl_q, prev_q;
  logic [NPIN-1:0] meta_d, lvl_d, prev_d;

  always_comb begin
    meta_d = pad_i;
    lvl_d  = meta_q;
    prev_d = lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_d;
      lvl_q  <= lvl_d;
      prev_q <= prev_d;
    end
  end

  assign lvl_o  = lvl_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int NPIN = 32
) (
  input  logic [NPIN-1:0] lvl_i,
  input  logic [NPIN-1:0] prev_i,
  input  logic [NPIN-1:0] fall_only_i,
  output logic [NPIN-1:0] edge_o
);
  for (genvar n = 0; n < NPIN; n++) begin : g_det
    logic rise, fall;
    assign rise      = lvl_i[n] & ~prev_i[n];
    assign fall      = ~lvl_i[n] & prev_i[n];
    assign edge_o[n] = fall | (rise & ~fall_only_i[n]);
  end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_edge_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   bus_rdata,
  input  logic [NPIN-1:0]   lvl_i,
  input  logic [NPIN-1:0]   edge_i,
  output logic [NPIN-1:0]   dir_o,
  output logic [NPIN-1:0]   ode_o,
  output logic [NPIN-1:0]   dat_o,
  output logic [NPIN-1:0]   evt_o,
  output logic [NPIN-1:0]   msk_o,
  output logic [NPIN-1:0]   edg_o
);
  reg_sel_e sel;
  logic wr_en, rd_en;
  logic dir_ld, ode_ld, dat_ld, msk_ld, edg_ld;
  logic [NPIN-1:0] dir_q, ode_q, dat_q, evt_q, msk_q, edg_q;
  logic [NPIN-1:0] evt_clr, evt_d;

  assign sel   = decode_sel(bus_addr);
  assign wr_en = bus_valid & bus_write;
  assign rd_en = bus_valid & ~bus_write;

  always_comb begin
    dir_ld  = wr_en && (sel == SEL_DIR);
    ode_ld  = wr_en && (sel == SEL_ODE);
    dat_ld  = wr_en && (sel == SEL_DAT);
    msk_ld  = wr_en && (sel == SEL_MSK);
    edg_ld  = wr_en && (sel == SEL_EDG);
    evt_clr = (wr_en && (sel == SEL_EVT)) ? bus_wdata : '0;
    evt_d   = (evt_q & ~evt_clr) | edge_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      ode_q <= '0;
      dat_q <= '0;
      evt_q <= '0;
      msk_q <= '0;
      edg_q <= '0;
    end else begin
      if (dir_ld) dir_q <= bus_wdata;
      if (ode_ld) ode_q <= bus_wdata;
      if (dat_ld) dat_q <= bus_wdata;
      if (msk_ld) msk_q <= bus_wdata;
      if (edg_ld) edg_q <= bus_wdata;
      evt_q <= evt_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      case (sel)
        SEL_DIR: bus_rdata = dir_q;
        SEL_ODE: bus_rdata = ode_q;
        SEL_DAT: bus_rdata = (dat_q & dir_q) | (lvl_i & ~dir_q);
        SEL_EVT: bus_rdata = evt_q;
        SEL_MSK: bus_rdata = msk_q;
        SEL_EDG: bus_rdata = edg_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign dir_o = dir_q;
  assign ode_o = ode_q;
  assign dat_o = dat_q;
  assign evt_o = evt_q;
  assign msk_o = msk_q;
  assign edg_o = edg_q;

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && (sel == SEL_EVT)) |-> ((evt_q & $past(bus_wdata & ~edge_i)) == '0)); // R9

  AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(evt_q) & ~$past(evt_clr)) & ~evt_q) == '0); // R9

  AST_EDGE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(edge_i) & ~evt_q) == '0); // R10
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_edge_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   bus_rdata,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  output logic              irq
);
  logic rst_n;
  logic [NPIN-1:0] lvl_pin, prev_pin, fall_only_pin, edge_pin;
  logic [NPIN-1:0] lvl_reg, edge_reg;
  logic [NPIN-1:0] dir_q, ode_q, dat_q, evt_q, msk_q, edg_q;

  gpio_rst_sync u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  gpio_in_sync #(.NPIN(NPIN)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pad_i  (pad_in),
    .lvl_o  (lvl_pin),
    .prev_o (prev_pin)
  );

  gpio_edge_det #(.NPIN(NPIN)) u_det (
    .lvl_i       (lvl_pin),
    .prev_i      (prev_pin),
    .fall_only_i (fall_only_pin),
    .edge_o      (edge_pin)
  );

  gpio_regfile #(.NPIN(NPIN)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .lvl_i     (lvl_reg),
    .edge_i    (edge_reg),
    .dir_o     (dir_q),
    .ode_o     (ode_q),
    .dat_o     (dat_q),
    .evt_o     (evt_q),
    .msk_o     (msk_q),
    .edg_o     (edg_q)
  );

  // Pin n lives at register bit NPIN-1-n
  for (genvar n = 0; n < NPIN; n++) begin : g_pin
    localparam int RB = NPIN - 1 - n;
    assign lvl_reg[RB]      = lvl_pin[n];
    assign edge_reg[RB]     = edge_pin[n];
    assign fall_only_pin[n] = edg_q[RB];
    assign pad_oe[n]        = dir_q[RB] & (~ode_q[RB] | ~dat_q[RB]);
    assign pad_out[n]       = dat_q[RB] & ~ode_q[RB];
  end

  assign irq = |(evt_q & msk_q);

  logic [NPIN-1:0] dir_pin, ode_pin;
  for (genvar n = 0; n < NPIN; n++) begin : g_chk
    assign dir_pin[n] = dir_q[NPIN-1-n];
    assign ode_pin[n] = ode_q[NPIN-1-n];
  end

  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_out & ode_pin) == '0); // R5

  AST_INPUT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~dir_pin) == '0); // R3

  AST_FALL_ONLY_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_pin & fall_only_pin & lvl_pin) == '0); // R8

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_q == '0) |-> !irq); // R11
endmodule

// File: tb/gpio_edge_port_bench.sv
module gpio_edge_port_bench;
  localparam int NPIN = 32;

  logic        clk = 1'b0;
  logic        arst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_item_t;
  exp_item_t sb_q[$];

  always #10 clk = ~clk;

  gpio_edge_port #(.NPIN(NPIN)) u_gpio_edge_port (
    .clk(clk), .arst_n(arst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  function automatic logic [31:0] rev(input logic [31:0] v);
    for (int i = 0; i < 32; i++) rev[i] = v[31-i];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  // driver: queue the expectation, then issue the read
  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    exp_item_t it;
    it.exp = exp; it.tag = tag;
    @(posedge clk); #2;
    sb_q.push_back(it);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(posedge clk); #2;
    bus_valid = 1'b0;
  endtask

  // monitor: mid-cycle, compare a read against the oldest expectation
  always @(negedge clk) begin
    if (bus_valid && !bus_write) begin
      if (sb_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL scoreboard actual=%h expected=none", bus_rdata);
      end else begin
        exp_item_t it;
        it = sb_q.pop_front();
        chk(it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic settle();
    repeat (4) @(posedge clk);
    #2;
  endtask

  task automatic set_pads(input logic [31:0] v);
    @(posedge clk); #2;
    pad_in = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] pad_pat;
    repeat (3) @(posedge clk); #2;
    arst_n = 1'b1;
    repeat (3) @(posedge clk); #2;

    // R1 reset state
    chk("R1 pad_oe", pad_oe, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    rd(5'h00, 32'h0, "R1 dir");
    rd(5'h04, 32'h0, "R1 ode");
    rd(5'h08, 32'h0, "R1 dat");
    rd(5'h0C, 32'h0, "R1 evt");
    rd(5'h10, 32'h0, "R1 msk");
    rd(5'h14, 32'h0, "R1 edg");

    // R2 / R3 / R4: pin 0 = bit 31, pin 31 = bit 0
    wr(5'h08, 32'h8000_0000);
    wr(5'h00, 32'h8000_0001);
    chk("R2 R3 pad_oe pins0,31", pad_oe, 32'h8000_0001);
    chk("R4 pad_out pin0 high pin31 low", pad_out, 32'h0000_0001);
    rd(5'h00, 32'h8000_0001, "R2 dir readback");
    wr(5'h10, 32'h0000_00F0);
    wr(5'h14, 32'h0000_0F00);
    rd(5'h10, 32'h0000_00F0, "R2 msk readback");
    rd(5'h14, 32'h0000_0F00, "R2 edg readback");
    wr(5'h10, 32'h0);
    wr(5'h14, 32'h0);

    // R5 open-drain
    wr(5'h04, 32'h8000_0001);
    chk("R5 od data1 released, data0 low", pad_oe, 32'h8000_0000);
    chk("R5 od pad_out", pad_out & pad_oe, 32'h0);
    wr(5'h08, 32'h0000_0001);
    chk("R5 od swap", pad_oe, 32'h0000_0001);
    wr(5'h04, 32'h0);

    // R6 data readback mix
    wr(5'h00, 32'h0000_FFFF);
    wr(5'h08, 32'h1234_5678);
    pad_pat = 32'hA5A5_0F0F;
    set_pads(pad_pat);
    settle();
    rd(5'h08, (32'h1234_5678 & 32'h0000_FFFF) | (rev(pad_pat) & 32'hFFFF_0000), "R6 dat mixed");
    wr(5'h00, 32'h0);
    rd(5'h08, rev(pad_pat), "R6 dat all inputs");
    set_pads(32'h0);
    settle();

    // R12 clear all, mask zero
    wr(5'h0C, 32'hFFFF_FFFF);
    wr(5'h10, 32'h0);
    rd(5'h0C, 32'h0, "R12 evt cleared");
    chk("R12 irq low", {31'h0, irq}, 32'h0);

    // R7 both edges on pin 3 (bit 28)
    set_pads(32'h0000_0008);
    settle();
    rd(5'h0C, 32'h1000_0000, "R7 rising sets");
    wr(5'h0C, 32'h1000_0000);
    set_pads(32'h0);
    settle();
    rd(5'h0C, 32'h1000_0000, "R7 falling sets");
    wr(5'h0C, 32'hFFFF_FFFF);

    // R7 latency: set on third edge after the pad change
    set_pads(32'h0000_0008);
    @(posedge clk); @(posedge clk); #2;
    rd(5'h0C, 32'h1000_0000, "R7 latency");
    wr(5'h0C, 32'hFFFF_FFFF);
    set_pads(32'h0);
    settle();
    wr(5'h0C, 32'hFFFF_FFFF);

    // R8 falling only on pin 5 (bit 26)
    wr(5'h14, 32'h0400_0000);
    set_pads(32'h0000_0020);
    settle();
    rd(5'h0C, 32'h0, "R8 rising ignored");
    set_pads(32'h0);
    settle();
    rd(5'h0C, 32'h0400_0000, "R8 falling sets");

    // R11 mask gating
    wr(5'h10, 32'h0400_0000);
    chk("R11 irq enabled", {31'h0, irq}, 32'h1);
    wr(5'h10, 32'h0800_0000);
    chk("R11 irq other mask", {31'h0, irq}, 32'h0);

    // R9 selective clear: events on bits 26 and 28
    set_pads(32'h0000_0008);
    settle();
    wr(5'h0C, 32'h1000_0000);
    rd(5'h0C, 32'h0400_0000, "R9 write one clears only its bit");
    wr(5'h0C, 32'h0);
    rd(5'h0C, 32'h0400_0000, "R9 write zero keeps");

    // R10 event arrives on the clearing edge: pin 7 (bit 24)
    set_pads(32'h0000_0088);
    @(posedge clk);
    wr(5'h0C, 32'h0500_0000);
    rd(5'h0C, 32'h0100_0000, "R10 event wins over clear");

    // R13 unmapped offsets
    wr(5'h18, 32'hFFFF_FFFF);
    wr(5'h01, 32'hFFFF_FFFF);
    rd(5'h18, 32'h0, "R13 unmapped read");
    rd(5'h00, 32'h0, "R13 dir untouched");
    rd(5'h10, 32'h0800_0000, "R13 msk untouched");
    rd(5'h0C, 32'h0100_0000, "R13 evt untouched");

    // R12 final
    wr(5'h10, 32'hFFFF_FFFF);
    chk("R11 irq with pending event", {31'h0, irq}, 32'h1);
    wr(5'h0C, 32'hFFFF_FFFF);
    wr(5'h10, 32'h0);
    chk("R12 irq low after clear", {31'h0, irq}, 32'h0);

    repeat (3) @(posedge clk); #2;
    if (sb_q.size() != 0) begin
      checks++; failures++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", sb_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule